// File: doc/BRIEF.md
# Addressable Tapped Shift Register

This block is a one-bit-wide chain of sixteen storage stages that advances only on clock edges where the clock enable is high. On such an edge the serial input enters the first stage and every other stage takes the value of the stage before it. When the enable is low, every stage keeps its value.

A four-bit address picks one stage and shows it on the tap output, so the delay from input to tap can be changed while the block runs. A second output always shows the last stage, so several blocks can be chained into longer lines. The stages take their power-up contents from a parameter word, and there is no reset. The block is a building primitive for delay lines, small cycling counters and short queues.

The block has no control sequencing. It has one implicit operating condition, SHIFT, entered when `ce_i` is high at a clock edge, and another, HOLD, entered when `ce_i` is low. It can move between the two on any edge.

Top module: `addr_shift16`

## Requirements
- R1: A one written with `ce_i` high first appears on `cascade_o` after exactly 16 enabled clock edges, not after 15.
- R2: On each enabled edge, stage 0 takes `din_i` and stage k takes the old stage k-1. With `addr_i` = a, `tap_o` shows the bit written a+1 enabled edges earlier, so address 0 is the newest bit.
- R3: While `ce_i` is low at a clock edge, no stage changes. The tap at every address and `cascade_o` keep their values whatever `din_i` does.
- R4: `cascade_o` always shows stage 15, whatever `addr_i` is. It therefore equals `tap_o` whenever `addr_i` is 15.
- R5: At power-up, stage k holds bit k of the `INIT` parameter, where bit 0 is the stage at address 0. `INIT` defaults to all zeros.
- R6: `tap_o` is a combinational read of the stages. A change on `addr_i` shows on `tap_o` in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| ce_i | input | 1 | Shift enable; stages advance only when high |
| din_i | input | 1 | Serial data into stage 0 |
| addr_i | input | 4 | Selects the stage driven onto `tap_o` |
| tap_o | output | 1 | Selected stage |
| cascade_o | output | 1 | Last stage, for chaining |

## Verification
On every cycle, the assertions check four things:
- an enabled edge places the input at address 0;
- a disabled edge leaves the chain end and any unchanged tap steady;
- the last stage advances from stage 14;
- the chain-end output matches the tap at address 15.

The exact 16-edge latency of a lone one, the power-up contents word, and same-cycle tap response to address changes can only be shown by the bench's scenarios. In those scenarios a scoreboard model is compared with both outputs after each edge, and all sixteen addresses are swept between edges.

// File: rtl/addr_shift_pkg.sv
package addr_shift_pkg;
    localparam int unsigned ASR_DEPTH_DFLT = 16;

    // Width of an index that reaches every stage of a chain
    function automatic int unsigned asr_sel_width(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/asr_stage_chain.sv
module asr_stage_chain #(
    parameter int unsigned       DEPTH = addr_shift_pkg::ASR_DEPTH_DFLT,
    parameter logic [DEPTH-1:0]  INIT  = '0
) (
    input  logic             clk_i,
    input  logic             en_i,
    input  logic             ser_i,
    output logic [DEPTH-1:0] stages_o
);
    // One flop per stage; stage 0 is the newest bit
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic bit_q = INIT[g];
        logic bit_d;

        if (g == 0) begin : g_head
            always_comb bit_d = ser_i;
        end else begin : g_body
            always_comb bit_d = stages_o[g-1];
        end

        always_ff @(posedge clk_i) begin
            if (en_i) begin
                bit_q <= bit_d;
            end
        end

        assign stages_o[g] = bit_q;
    end
endmodule

// File: rtl/asr_tap_select.sv
module asr_tap_select #(
    parameter int unsigned DEPTH = addr_shift_pkg::ASR_DEPTH_DFLT,
    parameter int unsigned AW    = addr_shift_pkg::asr_sel_width(DEPTH)
) (
    input  logic [DEPTH-1:0] stages_i,
    input  logic [AW-1:0]    sel_i,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (sel_i == AW'(k)) begin
                bit_o = stages_i[k];
            end
        end
    end
endmodule

// File: rtl/addr_shift16.sv
module addr_shift16 #(
    parameter int unsigned      DEPTH = addr_shift_pkg::ASR_DEPTH_DFLT,
    parameter logic [DEPTH-1:0] INIT  = '0,
    localparam int unsigned     AW    = addr_shift_pkg::asr_sel_width(DEPTH)
) (
    input  logic          clk_i,
    input  logic          ce_i,
    input  logic          din_i,
    input  logic [AW-1:0] addr_i,
    output logic          tap_o,
    output logic          cascade_o
);
    logic [DEPTH-1:0] stages;

    asr_stage_chain #(
        .DEPTH (DEPTH),
        .INIT  (INIT)
    ) u_chain (
        .clk_i    (clk_i),
        .en_i     (ce_i),
        .ser_i    (din_i),
        .stages_o (stages)
    );

    asr_tap_select #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_sel (
        .stages_i (stages),
        .sel_i    (addr_i),
        .bit_o    (tap_o)
    );

    assign cascade_o = stages[DEPTH-1];
endmodule

// File: rtl/addr_shift16_chk.sv
module addr_shift16_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input logic          clk_i,
    input logic          ce_i,
    input logic          din_i,
    input logic [AW-1:0] addr_i,
    input logic          tap_o,
    input logic          cascade_o
);
    // No reset exists; checks start once one edge has been seen
    logic armed = 1'b0;
    always_ff @(posedge clk_i) armed <= 1'b1;

    a_r1_last_stage_shift: assert property (@(posedge clk_i) disable iff (!armed)
        (ce_i && addr_i == AW'(DEPTH-2)) |=> (cascade_o == $past(tap_o)));

    a_r2_newest_at_zero: assert property (@(posedge clk_i) disable iff (!armed)
        ce_i |=> ((addr_i == '0) -> (tap_o == $past(din_i))));

    a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!armed)
        !ce_i |=> ($stable(cascade_o) && ($stable(addr_i) -> $stable(tap_o))));

    a_r4_cascade_is_last: assert property (@(posedge clk_i) disable iff (!armed)
        (addr_i == AW'(DEPTH-1)) |-> (cascade_o == tap_o));
endmodule

bind addr_shift16 addr_shift16_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) u_chk (
    .clk_i     (clk_i),
    .ce_i      (ce_i),
    .din_i     (din_i),
    .addr_i    (addr_i),
    .tap_o     (tap_o),
    .cascade_o (cascade_o)
);

// File: tb/addr_shift16_tb.sv
module addr_shift16_tb;
    localparam logic [15:0] INIT_W = 16'hA5C3;

    typedef struct {
        logic  tap;
        logic  casc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       ce_i = 1'b0;
    logic       din_i = 1'b0;
    logic [3:0] addr_i = 4'd0;
    logic       tap_o;
    logic       cascade_o;

    logic [15:0] model = INIT_W;
    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    addr_shift16 #(.INIT(INIT_W)) u_dut (
        .clk_i     (clk),
        .ce_i      (ce_i),
        .din_i     (din_i),
        .addr_i    (addr_i),
        .tap_o     (tap_o),
        .cascade_o (cascade_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected post-edge outputs
    task automatic step(input logic ce, input logic d, input logic [3:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        ce_i = ce; din_i = d; addr_i = a;
        if (ce) model = {model[14:0], d};
        e.tap = model[a]; e.casc = model[15]; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "tap_o", tap_o, e.tap);
                check(e.tag, "cascade_o", cascade_o, e.casc);
            end
        end
    end

    // Sweep every address between edges with the enable low
    task automatic sweep(input string tag);
        @(negedge clk);
        ce_i = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr_i = 4'(a);
            #0.5;
            check(tag, "tap_o sweep", tap_o, model[a]);
        end
        check(tag, "cascade_o sweep", cascade_o, model[15]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R5: power-up contents, before any edge
        for (int a = 0; a < 16; a++) begin
            addr_i = 4'(a);
            #0.5;
            check("R5", "init tap", tap_o, INIT_W[a]);
        end
        check("R5", "init cascade", cascade_o, INIT_W[15]);

        // Flush zeros, then R1: a lone one reaches the end after 16 edges
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 4'd15, "R2");
        step(1'b1, 1'b1, 4'd15, "R1");
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 4'd15, "R1");
        step(1'b1, 1'b0, 4'd15, "R1");

        // R2: irregular pattern with moving tap
        for (int i = 0; i < 40; i++) begin
            logic [15:0] pat = 16'h3B6D;
            step(1'b1, pat[i % 16], 4'((i * 7) % 16), "R2");
        end

        // R3: enable low, input toggling
        for (int i = 0; i < 12; i++) step(1'b0, i[0], 4'(i), "R3");
        sweep("R3");

        // R4: cascade independent of address, mixed enable
        for (int i = 0; i < 30; i++) step((i % 3) != 0, i[1] ^ i[2], 4'((i * 5) % 16), "R4");

        // R6: address change with no edge
        sweep("R6");
        for (int i = 0; i < 10; i++) step(1'b1, ~i[0], 4'd0, "R2");
        sweep("R6");

        @(posedge clk); #8;
        done = 1'b1;
        finish_run();
    end
endmodule